// File: doc/BRIEF.md
# Receive Resource Ring Fetcher

This block keeps the receive path supplied with buffers. Software places a ring of buffer descriptors in memory and sets a start, an end and a write pointer; the block owns the read pointer. Each descriptor occupies four 16-bit words: the low and high halves of a buffer address, then the low and high halves of a word count. On request the block reads the next descriptor through a simple 16-bit memory read port. It then loads a current-buffer address and a current-buffer word count. It also moves the read pointer forward and returns it to the start pointer when it reaches the end pointer.

Three sources can ask for a fetch. Software can issue a fetch command. Software can also clear a set exhaustion flag by writing one to it. The third source is the receive side, which reports its remaining word count; a value below a programmable threshold counts as low space. When the read pointer catches up with the software write pointer, the exhaustion flag is raised and reception is refused until software clears the flag. The 32-bit mode spaces the descriptor words one 32-bit slot apart and uses only the low half of each slot.

Top module: `rx_ring_fetcher`

## Requirements
- R1: After reset, fetch_busy, exhausted, mem_req, buf_addr, buf_words and rd_ptr are all 0, and the low-space threshold is 0x02F8.
- R2: While a fetch runs, mem_addr carries upper_addr in bits 31:16 and rd_ptr plus k·2 in bits 15:0 for descriptor word k = 0..3 in that order (k·4 when wide_mode is 1). The address is held until mem_ack.
- R3: buf_addr = {word1, word0} and buf_words = {word3, word2}. Both update together in the cycle after the fourth word is acknowledged, and at no other time.
- R4: When a fetch completes, rd_ptr advances by 8 (16 when wide_mode is 1). If the advanced value equals ring_end, rd_ptr takes ring_start instead.
- R5: When the value loaded into rd_ptr equals ring_wr, exhausted is set. rx_accept is 1 only when rx_enable is 1 and exhausted is 0.
- R6: A pulse on exh_clr while exhausted is 1 clears the flag and starts a fetch. While exhausted is 0, the pulse has no effect and starts no fetch.
- R7: A pulse on cmd_fetch while idle raises fetch_busy in the next cycle. fetch_busy stays high until the cycle after the fourth word is acknowledged.
- R8: A pulse on lvl_vld with lvl_words below the threshold starts a fetch. A value equal to or above the threshold does not. thr_wr_en loads the threshold.
- R9: Requests that arrive during a fetch, including one in the cycle of its last acknowledge, are merged into exactly one further fetch. That fetch starts immediately after the current one.
- R10: rp_wr_en loads rd_ptr from rp_wr_data only while fetch_busy is 0. While a fetch runs, the write is ignored.
- R11: If a completing fetch sets exhausted in the same cycle that exh_clr clears it, the flag ends set. The clear still requests another fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1: descriptor words spaced by 4 bytes |
| upper_addr | input | 16 | Upper 16 bits of every descriptor address |
| ring_start | input | 16 | Ring start pointer |
| ring_end | input | 16 | Ring end pointer (wrap point) |
| ring_wr | input | 16 | Software write pointer |
| rp_wr_en | input | 1 | Load read pointer |
| rp_wr_data | input | 16 | Value for the read pointer |
| cmd_fetch | input | 1 | Fetch command pulse |
| exh_clr | input | 1 | Write-one-to-clear pulse for the exhaustion flag |
| rx_enable | input | 1 | Receiver enabled |
| lvl_vld | input | 1 | Remaining word count is valid this cycle |
| lvl_words | input | 32 | Remaining word count of the current buffer |
| thr_wr_en | input | 1 | Load low-space threshold |
| thr_wr_data | input | 16 | New threshold |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory byte address |
| mem_ack | input | 1 | Read data valid, request accepted |
| mem_rdata | input | 16 | Read data |
| fetch_busy | output | 1 | Fetch command in progress |
| rd_ptr | output | 16 | Read pointer |
| buf_addr | output | 32 | Current buffer address |
| buf_words | output | 32 | Current buffer word count |
| exhausted | output | 1 | Resource exhaustion flag |
| rx_accept | output | 1 | Reception may proceed |

## Verification
Two coincidences are provoked. In the first, a completing fetch sets the exhaustion flag in the same cycle that software clears it. The bench detects the last-word acknowledge on the address bus and pulses exh_clr in exactly that cycle. It then expects the flag to stay set and a new fetch to start at once. In the second, fetch and low-space requests land during a stalled fetch, and the bench expects a single extra fetch, judged by the final read pointer. A behavioural model runs beside the design and is compared on every clock.

// File: rtl/rrf_pkg.sv
// Package: shared constants of the receive ring fetcher.
// Assumes a 16-bit memory word and four words per descriptor.
package rrf_pkg;
    localparam int WORD_W     = 16;
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int LVL_W      = 2 * WORD_W;
    localparam int BUF_W      = 2 * WORD_W;
endpackage

// File: rtl/rrf_req_ctrl.sv
// Request control: merges the three fetch sources, holds the
// low-space threshold and remembers requests that arrive mid-fetch.
// Assumes commit is a one-cycle pulse that only occurs while busy.
module rrf_req_ctrl
    import rrf_pkg::*;
#(
    parameter int THR_W = 16,
    parameter logic [THR_W-1:0] THR_RST = 16'h02F8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_fetch,
    input  logic             exh_clr,
    input  logic             exh_flag,
    input  logic             lvl_vld,
    input  logic [LVL_W-1:0] lvl_words,
    input  logic             thr_wr_en,
    input  logic [THR_W-1:0] thr_wr_data,
    input  logic             busy,
    input  logic             commit,
    output logic             launch
);
    logic [THR_W-1:0] thr_q;
    logic             pend_q;
    logic             low_space;
    logic             req_now;

    // Low space: the reported count is strictly below the threshold.
    assign low_space = lvl_vld && (lvl_words < LVL_W'(thr_q));
    // Any source asking this cycle; clearing only counts when the flag is set.
    assign req_now   = cmd_fetch || (exh_clr && exh_flag) || low_space;
    // Start now when idle, or chain directly after a completing fetch.
    assign launch    = (!busy && req_now) || (commit && (pend_q || req_now));

    // Threshold register with its reset value.
    always_ff @(posedge clk) begin
        if (!rst_n)         thr_q <= THR_RST;
        else if (thr_wr_en) thr_q <= thr_wr_data;
    end

    // Pending flag: set by a request during a fetch, consumed at completion.
    always_ff @(posedge clk) begin
        if (!rst_n)               pend_q <= 1'b0;
        else if (commit)          pend_q <= 1'b0;
        else if (busy && req_now) pend_q <= 1'b1;
    end
endmodule

// File: rtl/rrf_seq.sv
// Fetch sequencer: walks the four descriptor words over the memory
// port, keeps the first three in shadow registers and loads the
// current-buffer registers in one step when the last word arrives.
// Assumes the memory port returns data in the cycle of mem_ack.
module rrf_seq
    import rrf_pkg::*;
#(
    parameter int UPPER_W = 16,
    parameter int PTR_W   = 16,
    localparam int ADDR_W = UPPER_W + PTR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic               wide,
    input  logic [UPPER_W-1:0] upper,
    input  logic [PTR_W-1:0]   rp,
    input  logic               mem_ack,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               busy,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               commit,
    output logic [BUF_W-1:0]   buf_addr,
    output logic [BUF_W-1:0]   buf_words
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    logic [IDX_W-1:0]                     idx_q;
    logic [DESC_WORDS-2:0][WORD_W-1:0]    shadow;
    logic [PTR_W-1:0]                     offs;
    logic                                 take;

    assign take    = busy && mem_ack;
    assign commit  = take && (idx_q == LAST_IDX);
    assign mem_req = busy;

    // Byte offset of the current word: 2 bytes per word, 4 in wide mode.
    always_comb begin
        offs     = PTR_W'(idx_q) << (wide ? 2 : 1);
        mem_addr = {upper, rp + offs};
    end

    // Busy flag and word index of the running fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            idx_q <= '0;
        end else if (launch) begin
            busy  <= 1'b1;
            idx_q <= '0;
        end else if (commit) begin
            busy  <= 1'b0;
        end else if (take) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // One shadow register per word that precedes the last one.
    for (genvar g = 0; g < DESC_WORDS - 1; g++) begin : g_shadow
        logic [WORD_W-1:0] word_q;
        // Capture word g when it is acknowledged.
        always_ff @(posedge clk) begin
            if (!rst_n)                              word_q <= '0;
            else if (take && idx_q == IDX_W'(g))     word_q <= mem_rdata;
        end
        assign shadow[g] = word_q;
    end

    // Current-buffer registers, loaded together on the final word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_addr  <= '0;
            buf_words <= '0;
        end else if (commit) begin
            buf_addr  <= {shadow[1], shadow[0]};
            buf_words <= {mem_rdata, shadow[2]};
        end
    end
endmodule

// File: rtl/rrf_ptr.sv
// Pointer unit: owns the read pointer and the exhaustion flag.
// Advances and wraps on fetch completion; software loads are only
// taken while idle. Assumes ring_end is reached by whole descriptor steps.
module rrf_ptr
    import rrf_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             busy,
    input  logic             wide,
    input  logic [PTR_W-1:0] ring_start,
    input  logic [PTR_W-1:0] ring_end,
    input  logic [PTR_W-1:0] ring_wr,
    input  logic             rp_wr_en,
    input  logic [PTR_W-1:0] rp_wr_data,
    input  logic             exh_clr,
    output logic [PTR_W-1:0] rp,
    output logic             exh
);
    localparam logic [PTR_W-1:0] DESC_BYTES = PTR_W'(DESC_WORDS * 2);

    logic [PTR_W-1:0] step;
    logic [PTR_W-1:0] advanced;
    logic [PTR_W-1:0] rp_next;

    // Next pointer: one descriptor on, back to the start at the end mark.
    always_comb begin
        step     = wide ? (DESC_BYTES << 1) : DESC_BYTES;
        advanced = rp + step;
        rp_next  = (advanced == ring_end) ? ring_start : advanced;
    end

    // Read pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rp <= '0;
        else if (commit)              rp <= rp_next;
        else if (rp_wr_en && !busy)   rp <= rp_wr_data;
    end

    // Exhaustion flag: a catch-up with the write pointer wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                          exh <= 1'b0;
        else if (commit && rp_next == ring_wr) exh <= 1'b1;
        else if (exh_clr)                    exh <= 1'b0;
    end
endmodule

// File: rtl/rx_ring_fetcher.sv
// Receive ring fetcher top: connects request control, the fetch
// sequencer and the pointer unit. Assumes the configuration inputs
// (wide_mode, upper_addr, ring pointers) are steady during a fetch.
module rx_ring_fetcher
    import rrf_pkg::*;
#(
    parameter int UPPER_W = 16,
    parameter int PTR_W   = 16,
    parameter int THR_W   = 16,
    parameter logic [THR_W-1:0] THR_RST = 16'h02F8,
    localparam int ADDR_W = UPPER_W + PTR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wide_mode,
    input  logic [UPPER_W-1:0] upper_addr,
    input  logic [PTR_W-1:0]   ring_start,
    input  logic [PTR_W-1:0]   ring_end,
    input  logic [PTR_W-1:0]   ring_wr,
    input  logic               rp_wr_en,
    input  logic [PTR_W-1:0]   rp_wr_data,
    input  logic               cmd_fetch,
    input  logic               exh_clr,
    input  logic               rx_enable,
    input  logic               lvl_vld,
    input  logic [LVL_W-1:0]   lvl_words,
    input  logic               thr_wr_en,
    input  logic [THR_W-1:0]   thr_wr_data,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_ack,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               fetch_busy,
    output logic [PTR_W-1:0]   rd_ptr,
    output logic [BUF_W-1:0]   buf_addr,
    output logic [BUF_W-1:0]   buf_words,
    output logic               exhausted,
    output logic               rx_accept
);
    logic launch;
    logic commit;

    // Reception is allowed only when enabled and not exhausted.
    assign rx_accept = rx_enable && !exhausted;

    rrf_req_ctrl #(.THR_W(THR_W), .THR_RST(THR_RST)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_fetch   (cmd_fetch),
        .exh_clr     (exh_clr),
        .exh_flag    (exhausted),
        .lvl_vld     (lvl_vld),
        .lvl_words   (lvl_words),
        .thr_wr_en   (thr_wr_en),
        .thr_wr_data (thr_wr_data),
        .busy        (fetch_busy),
        .commit      (commit),
        .launch      (launch)
    );

    rrf_seq #(.UPPER_W(UPPER_W), .PTR_W(PTR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .wide      (wide_mode),
        .upper     (upper_addr),
        .rp        (rd_ptr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .busy      (fetch_busy),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .commit    (commit),
        .buf_addr  (buf_addr),
        .buf_words (buf_words)
    );

    rrf_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .busy       (fetch_busy),
        .wide       (wide_mode),
        .ring_start (ring_start),
        .ring_end   (ring_end),
        .ring_wr    (ring_wr),
        .rp_wr_en   (rp_wr_en),
        .rp_wr_data (rp_wr_data),
        .exh_clr    (exh_clr),
        .rp         (rd_ptr),
        .exh        (exhausted)
    );
endmodule

// File: rtl/rrf_checker.sv
// Checker: temporal properties of the ring fetcher, bound to the top.
// Assumes configuration inputs stay steady during a fetch.
module rrf_checker #(
    parameter int ADDR_W = 32,
    parameter int PTR_W  = 16,
    parameter int BUF_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_busy,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BUF_W-1:0]  buf_addr,
    input logic [BUF_W-1:0]  buf_words,
    input logic [PTR_W-1:0]  rd_ptr,
    input logic              exhausted,
    input logic              rx_accept
);
    // Address of an unanswered request is held.
    assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // Current-buffer registers move only after an acknowledged word.
    assert_buf_atomic_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_busy && mem_ack) |=> ($stable(buf_addr) && $stable(buf_words)));

    // A running fetch without an acknowledge leaves the pointer alone.
    assert_ptr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_busy && !mem_ack) |=> $stable(rd_ptr));

    // No reception while exhausted.
    assert_no_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exhausted |-> !rx_accept);

    // The flag only rises from a completing fetch.
    assert_exh_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exhausted) |-> $past(fetch_busy && mem_ack));

    // Busy ends only on an acknowledged word.
    assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fetch_busy) |-> $past(mem_ack));
endmodule

bind rx_ring_fetcher rrf_checker #(
    .ADDR_W (ADDR_W),
    .PTR_W  (PTR_W),
    .BUF_W  (rrf_pkg::BUF_W)
) u_rrf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_busy (fetch_busy),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .buf_addr   (buf_addr),
    .buf_words  (buf_words),
    .rd_ptr     (rd_ptr),
    .exhausted  (exhausted),
    .rx_accept  (rx_accept)
);

// File: tb/test_rx_ring_fetcher.sv
module test_rx_ring_fetcher;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic [15:0] upper_addr = 16'h1234;
    logic [15:0] ring_start = 16'h0100;
    logic [15:0] ring_end = 16'h0120;
    logic [15:0] ring_wr = 16'h0118;
    logic        rp_wr_en = 1'b0;
    logic [15:0] rp_wr_data = '0;
    logic        cmd_fetch = 1'b0;
    logic        exh_clr = 1'b0;
    logic        rx_enable = 1'b1;
    logic        lvl_vld = 1'b0;
    logic [31:0] lvl_words = '0;
    logic        thr_wr_en = 1'b0;
    logic [15:0] thr_wr_data = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        fetch_busy;
    logic [15:0] rd_ptr;
    logic [31:0] buf_addr;
    logic [31:0] buf_words;
    logic        exhausted;
    logic        rx_accept;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit stall = 1'b0;
    bit ack_tog = 1'b0;

    rx_ring_fetcher i_rx_ring_fetcher (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [15:0] mem_f(input logic [31:0] a);
        return (a[15:0] * 16'd5) ^ a[31:16] ^ 16'h3C69;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Memory model: answers on the falling edge, optionally every other cycle.
    always @(negedge clk) begin
        ack_tog <= ~ack_tog;
        mem_ack <= mem_req && (!stall || ack_tog);
        mem_rdata <= mem_f(mem_addr);
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > MAX_CYCLES) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cycles, MAX_CYCLES);
            finish_up();
        end
    end

    // Behavioural reference model, compared shortly after every edge.
    bit          m_busy, m_pend, m_exh;
    int          m_cnt;
    logic [15:0] m_rp, m_thr;
    logic [31:0] m_ba, m_bw;
    logic [15:0] m_w [4];
    always @(posedge clk) begin
        bit req, fin, go;
        logic [15:0] nx;
        if (!rst_n) begin
            m_busy = 0; m_pend = 0; m_exh = 0; m_cnt = 0;
            m_rp = 0; m_thr = 16'h02F8; m_ba = 0; m_bw = 0;
        end else begin
            req = cmd_fetch || (exh_clr && m_exh) || (lvl_vld && lvl_words < {16'h0, m_thr});
            fin = m_busy && mem_ack && m_cnt == 3;
            go  = (!m_busy && req) || (fin && (m_pend || req));
            if (thr_wr_en) m_thr = thr_wr_data;
            if (m_busy && mem_ack) m_w[m_cnt] = mem_rdata;
            if (fin) begin
                m_ba = {m_w[1], m_w[0]};
                m_bw = {m_w[3], m_w[2]};
                nx = m_rp + (wide_mode ? 16'd16 : 16'd8);
                if (nx == ring_end) nx = ring_start;
                m_rp = nx;
                if (nx == ring_wr) m_exh = 1;
                else if (exh_clr) m_exh = 0;
            end else begin
                if (exh_clr) m_exh = 0;
                if (rp_wr_en && !m_busy) m_rp = rp_wr_data;
            end
            if (fin) m_pend = 0;
            else if (m_busy && req) m_pend = 1;
            if (go) begin m_busy = 1; m_cnt = 0; end
            else if (fin) m_busy = 0;
            else if (m_busy && mem_ack) m_cnt++;
        end
        #2;
        chk(fetch_busy == m_busy, "R7 model busy", 32'(fetch_busy), 32'(m_busy));
        chk(rd_ptr == m_rp, "R4 model rd_ptr", 32'(rd_ptr), 32'(m_rp));
        chk(exhausted == m_exh, "R5 model exhausted", 32'(exhausted), 32'(m_exh));
        chk(rx_accept == (rx_enable && !m_exh), "R5 model rx_accept", 32'(rx_accept), 32'(rx_enable && !m_exh));
        chk(buf_addr == m_ba && buf_words == m_bw, "R3 model buffer", buf_addr, m_ba);
        if (m_busy)
            chk(mem_addr == {upper_addr, m_rp + 16'(m_cnt * (wide_mode ? 4 : 2))},
                "R2 model mem_addr", mem_addr, {upper_addr, m_rp + 16'(m_cnt * (wide_mode ? 4 : 2))});
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (fetch_busy) tick();
    endtask

    task automatic fetch();
        tick(); cmd_fetch = 1;
        tick(); cmd_fetch = 0;
        wait_idle();
    endtask

    task automatic set_rp(input logic [15:0] v);
        tick(); rp_wr_en = 1; rp_wr_data = v;
        tick(); rp_wr_en = 0;
    endtask

    initial begin
        logic [31:0] base;
        int n;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk(fetch_busy == 0 && mem_req == 0, "R1 idle after reset", 32'(fetch_busy), 0);
        chk(exhausted == 0 && rd_ptr == 0, "R1 flag and pointer", 32'(rd_ptr), 0);
        chk(buf_addr == 0 && buf_words == 0, "R1 buffer regs", buf_addr, 0);

        // R7 busy window: four acknowledged words, no stall.
        set_rp(16'h0100);
        tick(); cmd_fetch = 1;
        tick(); cmd_fetch = 0;
        n = 0;
        while (fetch_busy) begin n++; tick(); end
        chk(n == 4, "R7 busy cycles", 32'(n), 4);
        // R3 buffer contents, narrow layout.
        base = {16'h1234, 16'h0100};
        chk(buf_addr == {mem_f(base + 2), mem_f(base)}, "R3 buf_addr", buf_addr, {mem_f(base + 2), mem_f(base)});
        chk(buf_words == {mem_f(base + 6), mem_f(base + 4)}, "R3 buf_words", buf_words, {mem_f(base + 6), mem_f(base + 4)});
        chk(rd_ptr == 16'h0108, "R4 advance by 8", 32'(rd_ptr), 32'h108);

        fetch();
        fetch();
        chk(rd_ptr == 16'h0118 && exhausted, "R5 catch-up sets flag", 32'(exhausted), 1);
        chk(rx_accept == 0, "R5 refuse while exhausted", 32'(rx_accept), 0);

        // R6 clear starts a fetch; R4 wrap at the end mark.
        tick(); exh_clr = 1;
        tick(); exh_clr = 0;
        chk(fetch_busy == 1 && exhausted == 0, "R6 clear starts fetch", 32'(fetch_busy), 1);
        wait_idle();
        chk(rd_ptr == 16'h0100, "R4 wrap to start", 32'(rd_ptr), 32'h100);
        // R6 clearing an idle flag does nothing.
        tick(); exh_clr = 1;
        tick(); exh_clr = 0;
        chk(fetch_busy == 0, "R6 no fetch on idle clear", 32'(fetch_busy), 0);
        tick();
        chk(fetch_busy == 0 && rd_ptr == 16'h0100, "R6 pointer unchanged", 32'(rd_ptr), 32'h100);

        // R11 clear and set in the same cycle.
        tick(); ring_wr = 16'h0108;
        fetch();
        chk(exhausted == 1, "R11 flag set before", 32'(exhausted), 1);
        set_rp(16'h0100);
        tick(); cmd_fetch = 1;
        tick(); cmd_fetch = 0;
        while (!(mem_ack && mem_addr[15:0] == 16'h0106)) begin tick(); #1; end
        exh_clr = 1;
        tick(); exh_clr = 0;
        chk(exhausted == 1, "R11 set wins over clear", 32'(exhausted), 1);
        chk(fetch_busy == 1, "R11 clear still requests fetch", 32'(fetch_busy), 1);
        wait_idle();
        chk(rd_ptr == 16'h0110 && exhausted == 1, "R11 chained fetch done", 32'(rd_ptr), 32'h110);
        tick(); exh_clr = 1;
        tick(); exh_clr = 0;
        wait_idle();

        // R9 merged requests with a stalling memory.
        tick(); ring_end = 16'h0140; ring_wr = 16'h0000; stall = 1;
        set_rp(16'h0100);
        tick(); cmd_fetch = 1;
        tick(); cmd_fetch = 0;
        tick(); tick();
        cmd_fetch = 1; lvl_vld = 1; lvl_words = 32'h1;
        tick(); cmd_fetch = 0; lvl_vld = 0;
        tick(); cmd_fetch = 1;
        tick(); cmd_fetch = 0;
        wait_idle();
        chk(rd_ptr == 16'h0110, "R9 one extra fetch", 32'(rd_ptr), 32'h110);

        // R10 pointer write during a fetch is ignored.
        tick(); cmd_fetch = 1;
        tick(); cmd_fetch = 0; rp_wr_en = 1; rp_wr_data = 16'h0300;
        tick(); rp_wr_en = 0;
        wait_idle();
        chk(rd_ptr == 16'h0118, "R10 write ignored while busy", 32'(rd_ptr), 32'h118);
        stall = 0;

        // R8 threshold boundaries.
        tick(); lvl_vld = 1; lvl_words = 32'h02F8;
        tick(); lvl_vld = 0;
        chk(fetch_busy == 0, "R8 at reset threshold no fetch", 32'(fetch_busy), 0);
        tick(); lvl_vld = 1; lvl_words = 32'h02F7;
        tick(); lvl_vld = 0;
        chk(fetch_busy == 1, "R8 below reset threshold", 32'(fetch_busy), 1);
        wait_idle();
        tick(); thr_wr_en = 1; thr_wr_data = 16'h0010;
        tick(); thr_wr_en = 0; lvl_vld = 1; lvl_words = 32'h10;
        tick(); lvl_vld = 0;
        chk(fetch_busy == 0, "R8 at new threshold no fetch", 32'(fetch_busy), 0);
        tick(); lvl_vld = 1; lvl_words = 32'h0F;
        tick(); lvl_vld = 0;
        chk(fetch_busy == 1, "R8 below new threshold", 32'(fetch_busy), 1);
        wait_idle();
        chk(rd_ptr == 16'h0128, "R8 fetches done", 32'(rd_ptr), 32'h128);

        // R2 wide layout.
        tick(); wide_mode = 1; ring_start = 16'h0200; ring_end = 16'h0240; upper_addr = 16'h00A5;
        set_rp(16'h0200);
        fetch();
        base = {16'h00A5, 16'h0200};
        chk(buf_addr == {mem_f(base + 4), mem_f(base)}, "R2 wide address words", buf_addr, {mem_f(base + 4), mem_f(base)});
        chk(buf_words == {mem_f(base + 12), mem_f(base + 8)}, "R2 wide count words", buf_words, {mem_f(base + 12), mem_f(base + 8)});
        chk(rd_ptr == 16'h0210, "R4 wide advance by 16", 32'(rd_ptr), 32'h210);

        // R5 receiver disabled.
        tick(); rx_enable = 0;
        tick();
        chk(rx_accept == 0, "R5 disabled receiver", 32'(rx_accept), 0);
        tick();
        finish_up();
    end
endmodule